// File: doc/BRIEF.md
# Flash Command Unlock Decoder

This block is the command front end of a parallel NOR flash. Each host write, given as an address, a data word and a one-cycle strobe, is matched against unlock patterns at two fixed addresses. Complete sequences either choose what the read path shows (memory array, status register or identifier bytes) or send a one-cycle request to the write state machine that programs, erases and protects the array. A sector erase, protect or unprotect request carries the sector number taken from the top address bits.

The set of accepted commands follows the write state machine's busy and suspended indications, together with the kind of operation the decoder last launched. A command that is not allowed at that moment is dropped with no effect. A combinational identifier path returns the manufacturer code, the device code and a per-sector protection byte for a read offset.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read select `rd_sel` is 2'b00 (array) and no request pulse is high.
- R2: A long sequence begins with data AAh at address 5555h, followed by 55h at 2AAAh. Only address bits 14..0 and data bits 7..0 are compared.
- R3: A third write at 5555h sets the read select. F0h selects array (2'b00), 70h selects status (2'b01) and 90h selects identifier (2'b10).
- R4: A third write of A0h at 5555h pulses `go_prog` and sets `rd_sel` to status.
- R5: 80h at step three, then AAh@5555h, then 55h@2AAAh, then one final write. A final 10h at 5555h pulses `go_chip_erase`. A final 30h at any address pulses `go_sect_erase`, with `sect_addr` equal to address bits 19..16. Both set status mode.
- R6: 60h at step three, then an unlock pair, then one final write. A final 20h pulses `go_protect` and a final 40h pulses `go_unprotect`, each with `sect_addr` from address bits 19..16 and status mode. While `wp_n` is low both are refused and the read select is left unchanged.
- R7: B0h and D0h are single writes at any address. B0h pulses `go_suspend` only while a sector erase is busy and not suspended. D0h pulses `go_resume` only while suspended. Both set status mode.
- R8: While busy with a program or protect operation, only 70h is accepted. While busy with an erase, 70h and B0h are accepted. While suspended, only F0h, 70h and D0h are accepted.
- R9: A write that does not match the next expected step returns the decoder to idle. It raises no pulse and does not change the read select.
- R10: A third write of 50h at 5555h pulses `go_clr_status` and leaves the read select unchanged.
- R11: `id_byte` depends on read address bits 1..0. Offset 0 gives C2h. Offset 1 gives DEV_CODE (FAh by default). Offset 2 gives C2h when the sector in bits 19..16 is protected and 00h when it is not. Offset 3 gives 00h.
- R12: A request pulse is high exactly in the cycle after the completing write. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 20 | Captured write address |
| wr_data | input | 16 | Captured write data; only the low byte is decoded |
| wsm_busy | input | 1 | Write state machine is running an operation |
| wsm_susp | input | 1 | Write state machine is suspended in an erase |
| wp_n | input | 1 | Low refuses protect and unprotect |
| rd_addr | input | 20 | Read address for the identifier path |
| sect_prot | input | 16 | Protection flag per sector |
| rd_sel | output | 2 | Read path: 00 array, 01 status, 10 identifier |
| id_byte | output | 8 | Identifier byte for rd_addr |
| go_prog | output | 1 | Program request pulse |
| go_chip_erase | output | 1 | Chip erase request pulse |
| go_sect_erase | output | 1 | Sector erase request pulse |
| go_suspend | output | 1 | Erase suspend request pulse |
| go_resume | output | 1 | Erase resume request pulse |
| go_clr_status | output | 1 | Clear status request pulse |
| go_protect | output | 1 | Sector protect request pulse |
| go_unprotect | output | 1 | Sector unprotect request pulse |
| sect_addr | output | 4 | Sector for erase, protect or unprotect |

## Verification
A sequence state left behind by a broken or refused sequence is only visible on a later write. A stray pulse, or a read select that fails to move, appears one cycle after the next completing write. A wrong record of the last operation kind shows up only when B0h is written during a busy phase: a suspend pulse appears after a chip erase, or is missing after a sector erase. The bench drives interleaved good, corrupted and refused sequences. It compares the read select, every pulse and the sector field against its model on every clock.

// File: rtl/cir_pkg.sv
package cir_pkg;

  typedef enum logic [1:0] {RD_ARRAY = 2'b00, RD_STATUS = 2'b01, RD_ID = 2'b10} rd_mode_e;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_CHIP = 2'd1, OP_SECT = 2'd2} op_kind_e;

  typedef enum logic [3:0] {
    CM_NONE, CM_RESET, CM_ID, CM_PROG, CM_ERSET, CM_STAT, CM_CLR, CM_PRSET,
    CM_CHIP, CM_SECT, CM_SUSP, CM_RES, CM_PROT, CM_UNPROT
  } cmd_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  MFR_CODE = 8'hC2;

  // Whether a command may take effect in the current write state machine phase.
  function automatic logic cmd_allowed(cmd_e c, logic busy, logic susp, op_kind_e k);
    if (c == CM_NONE) return 1'b0;
    if (susp) return (c == CM_RESET) || (c == CM_STAT) || (c == CM_RES);
    if (busy) return (c == CM_STAT) || ((c == CM_SUSP) && (k == OP_SECT));
    return (c != CM_SUSP) && (c != CM_RES);
  endfunction

  function automatic logic is_setup(cmd_e c);
    return (c == CM_ERSET) || (c == CM_PRSET);
  endfunction

  function automatic logic needs_wp(cmd_e c);
    return (c == CM_PROT) || (c == CM_UNPROT);
  endfunction

  function automatic rd_mode_e mode_after(cmd_e c, rd_mode_e cur);
    case (c)
      CM_RESET: return RD_ARRAY;
      CM_ID:    return RD_ID;
      CM_CLR:   return cur;
      default:  return RD_STATUS;
    endcase
  endfunction

  function automatic logic [7:0] id_value(logic [1:0] off, logic prot, logic [7:0] dev);
    case (off)
      2'd0:    return MFR_CODE;
      2'd1:    return dev;
      2'd2:    return prot ? MFR_CODE : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cir_seq.sv
module cir_seq
  import cir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [14:0] addr_lo,
  input  logic [7:0]  data_lo,
  input  logic        cand_ok,
  output cmd_e        cand
);

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_A1, SQ_A2, SQ_E3, SQ_E4, SQ_E5, SQ_P3, SQ_P4, SQ_P5
  } seq_e;

  seq_e st, st_nxt;
  logic at_a, at_b, key_a, key_b;

  assign at_a  = (addr_lo == UNLOCK_A);
  assign at_b  = (addr_lo == UNLOCK_B);
  assign key_a = at_a && (data_lo == KEY_A);
  assign key_b = at_b && (data_lo == KEY_B);

  always_comb begin
    cand   = CM_NONE;
    st_nxt = SQ_IDLE;
    case (st)
      SQ_IDLE: begin
        if (key_a) st_nxt = SQ_A1;
        else if (data_lo == 8'hB0) cand = CM_SUSP;
        else if (data_lo == 8'hD0) cand = CM_RES;
      end
      SQ_A1: if (key_b) st_nxt = SQ_A2;
      SQ_A2: if (at_a) begin
        case (data_lo)
          8'hF0:   cand = CM_RESET;
          8'h90:   cand = CM_ID;
          8'hA0:   cand = CM_PROG;
          8'h80:   cand = CM_ERSET;
          8'h70:   cand = CM_STAT;
          8'h50:   cand = CM_CLR;
          8'h60:   cand = CM_PRSET;
          default: cand = CM_NONE;
        endcase
      end
      SQ_E3: if (key_a) st_nxt = SQ_E4;
      SQ_E4: if (key_b) st_nxt = SQ_E5;
      SQ_E5: begin
        if (at_a && data_lo == 8'h10) cand = CM_CHIP;
        else if (data_lo == 8'h30) cand = CM_SECT;
      end
      SQ_P3: if (key_a) st_nxt = SQ_P4;
      SQ_P4: if (key_b) st_nxt = SQ_P5;
      SQ_P5: begin
        if (data_lo == 8'h20) cand = CM_PROT;
        else if (data_lo == 8'h40) cand = CM_UNPROT;
      end
      default: st_nxt = SQ_IDLE;
    endcase
    if (cand == CM_ERSET && cand_ok) st_nxt = SQ_E3;
    if (cand == CM_PRSET && cand_ok) st_nxt = SQ_P3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else if (wr_en) st <= st_nxt;
  end

endmodule

// File: rtl/cir_gate.sv
module cir_gate
  import cir_pkg::*;
(
  input  cmd_e     cand,
  input  logic     wsm_busy,
  input  logic     wsm_susp,
  input  logic     wp_n,
  input  op_kind_e op_kind,
  output logic     cand_ok
);

  always_comb begin
    cand_ok = cmd_allowed(cand, wsm_busy, wsm_susp, op_kind);
    if (needs_wp(cand) && !wp_n) cand_ok = 1'b0;
  end

endmodule

// File: rtl/cir_idmux.sv
module cir_idmux
  import cir_pkg::*;
#(
  parameter int          SECT_W   = 4,
  parameter logic [7:0]  DEV_CODE = 8'hFA,
  localparam int         NSECT    = 1 << SECT_W
) (
  input  logic [1:0]        offset,
  input  logic [SECT_W-1:0] sector,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [7:0]        id_byte
);

  assign id_byte = id_value(offset, sect_prot[sector], DEV_CODE);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import cir_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         DATA_W   = 16,
  parameter int         SECT_W   = 4,
  parameter logic [7:0] DEV_CODE = 8'hFA,
  localparam int        NSECT    = 1 << SECT_W,
  localparam int        SECT_LSB = ADDR_W - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wsm_busy,
  input  logic              wsm_susp,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [1:0]        rd_sel,
  output logic [7:0]        id_byte,
  output logic              go_prog,
  output logic              go_chip_erase,
  output logic              go_sect_erase,
  output logic              go_suspend,
  output logic              go_resume,
  output logic              go_clr_status,
  output logic              go_protect,
  output logic              go_unprotect,
  output logic [SECT_W-1:0] sect_addr
);

  cmd_e     cand;
  logic     cand_ok;
  logic     fire;
  op_kind_e op_kind;
  rd_mode_e rd_mode;
  logic [7:0] pulse_q;
  logic unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-1:8], wr_addr[SECT_LSB-1:15], rd_addr[SECT_LSB-1:2]};

  cir_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr_lo(wr_addr[14:0]), .data_lo(wr_data[7:0]),
    .cand_ok(cand_ok), .cand(cand)
  );

  cir_gate u_gate (
    .cand(cand), .wsm_busy(wsm_busy), .wsm_susp(wsm_susp),
    .wp_n(wp_n), .op_kind(op_kind), .cand_ok(cand_ok)
  );

  cir_idmux #(.SECT_W(SECT_W), .DEV_CODE(DEV_CODE)) u_id (
    .offset(rd_addr[1:0]), .sector(rd_addr[ADDR_W-1:SECT_LSB]),
    .sect_prot(sect_prot), .id_byte(id_byte)
  );

  // A command takes effect: the write completes it and it is allowed now.
  assign fire = wr_en && cand_ok && !is_setup(cand);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode   <= RD_ARRAY;
      pulse_q   <= '0;
      sect_addr <= '0;
      op_kind   <= OP_PROG;
    end else begin
      pulse_q <= '0;
      if (fire) begin
        rd_mode <= mode_after(cand, rd_mode);
        case (cand)
          CM_PROG:   begin pulse_q[0] <= 1'b1; op_kind <= OP_PROG; end
          CM_CHIP:   begin pulse_q[1] <= 1'b1; op_kind <= OP_CHIP; end
          CM_SECT:   begin pulse_q[2] <= 1'b1; op_kind <= OP_SECT; end
          CM_SUSP:   pulse_q[3] <= 1'b1;
          CM_RES:    pulse_q[4] <= 1'b1;
          CM_CLR:    pulse_q[5] <= 1'b1;
          CM_PROT:   begin pulse_q[6] <= 1'b1; op_kind <= OP_PROG; end
          CM_UNPROT: begin pulse_q[7] <= 1'b1; op_kind <= OP_PROG; end
          default:   ;
        endcase
        if (cand == CM_SECT || cand == CM_PROT || cand == CM_UNPROT)
          sect_addr <= wr_addr[ADDR_W-1:SECT_LSB];
      end
    end
  end

  assign rd_sel        = rd_mode;
  assign go_prog       = pulse_q[0];
  assign go_chip_erase = pulse_q[1];
  assign go_sect_erase = pulse_q[2];
  assign go_suspend    = pulse_q[3];
  assign go_resume     = pulse_q[4];
  assign go_clr_status = pulse_q[5];
  assign go_protect    = pulse_q[6];
  assign go_unprotect  = pulse_q[7];

endmodule

// File: rtl/cir_chk.sv
module cir_chk #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wsm_busy,
  input logic              wsm_susp,
  input logic              wp_n,
  input logic [1:0]        rd_sel,
  input logic [7:0]        pulses,
  input logic [SECT_W-1:0] sect_addr
);

  logic launch;
  assign launch = pulses[0] | pulses[1] | pulses[2] | pulses[6] | pulses[7];

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pulses));
  a_r12_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != 8'h00) |-> $past(wr_en));
  a_r4_launch_status: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (rd_sel == 2'b01));
  a_r5_sector_field: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[2] |-> (sect_addr == $past(wr_addr[ADDR_W-1 -: SECT_W])));
  a_r6_wp_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> (!pulses[6] && !pulses[7]));
  a_r7_resume_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
    !wsm_susp |=> !pulses[4]);
  a_r7_no_double_susp: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_susp |=> !pulses[3]);
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_busy && !wsm_susp) |=> !(launch || pulses[4] || pulses[5]));

endmodule

bind flash_cmd_decoder cir_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .wp_n(wp_n), .rd_sel(rd_sel),
  .pulses({go_unprotect, go_protect, go_clr_status, go_resume,
           go_suspend, go_sect_erase, go_chip_erase, go_prog}),
  .sect_addr(sect_addr)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wsm_busy = 1'b0, wsm_susp = 1'b0, wp_n = 1'b1;
  logic [19:0] rd_addr = '0;
  logic [15:0] sect_prot = 16'h0420;
  logic [1:0]  rd_sel;
  logic [7:0]  id_byte;
  logic        go_prog, go_chip_erase, go_sect_erase, go_suspend;
  logic        go_resume, go_clr_status, go_protect, go_unprotect;
  logic [3:0]  sect_addr;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .wp_n(wp_n), .rd_addr(rd_addr),
    .sect_prot(sect_prot), .rd_sel(rd_sel), .id_byte(id_byte), .go_prog(go_prog),
    .go_chip_erase(go_chip_erase), .go_sect_erase(go_sect_erase),
    .go_suspend(go_suspend), .go_resume(go_resume), .go_clr_status(go_clr_status),
    .go_protect(go_protect), .go_unprotect(go_unprotect), .sect_addr(sect_addr)
  );

  // Bit order of the bench pulse vector.
  localparam int P_PROG = 0, P_CHIP = 1, P_SECT = 2, P_SUSP = 3;
  localparam int P_RES = 4, P_CLR = 5, P_PROT = 6, P_UNPR = 7;
  localparam int K_PREFIX = 100, K_BAD = 101, K_ARR = 102, K_ID = 103, K_STAT = 104;
  localparam int K_ESET = 105, K_PSET = 106;

  logic [7:0] dut_p;
  assign dut_p = {go_unprotect, go_protect, go_clr_status, go_resume,
                  go_suspend, go_sect_erase, go_chip_erase, go_prog};

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int a; int d; } wr_t;
  wr_t q[$];
  int  m_mode = 0;
  int  m_pulse = 0;
  int  m_sect = 0;
  int  m_last = 0;   // 0 program-like, 1 chip, 2 sector

  function automatic int classify();
    int n = q.size();
    int a[6], d[6];
    for (int i = 0; i < n; i++) begin a[i] = q[i].a & 'h7FFF; d[i] = q[i].d & 'hFF; end
    if (n == 1 && !(a[0] == 'h5555 && d[0] == 'hAA)) begin
      if (d[0] == 'hB0) return P_SUSP;
      if (d[0] == 'hD0) return P_RES;
      return K_BAD;
    end
    if (n == 1) return K_PREFIX;
    if (!(a[1] == 'h2AAA && d[1] == 'h55)) return K_BAD;
    if (n == 2) return K_PREFIX;
    if (a[2] != 'h5555) return K_BAD;
    if (n == 3) begin
      case (d[2])
        'hF0: return K_ARR;  'h90: return K_ID;  'h70: return K_STAT;
        'hA0: return P_PROG; 'h50: return P_CLR;
        'h80: return K_ESET; 'h60: return K_PSET;
        default: return K_BAD;
      endcase
    end
    if (n == 4) return (a[3] == 'h5555 && d[3] == 'hAA) ? K_PREFIX : K_BAD;
    if (n == 5) return (a[4] == 'h2AAA && d[4] == 'h55) ? K_PREFIX : K_BAD;
    if (d[2] == 'h80) begin
      if (d[5] == 'h10 && a[5] == 'h5555) return P_CHIP;
      if (d[5] == 'h30) return P_SECT;
    end else begin
      if (d[5] == 'h20) return P_PROT;
      if (d[5] == 'h40) return P_UNPR;
    end
    return K_BAD;
  endfunction

  function automatic bit allowed(int k);
    if ((k == P_PROT || k == P_UNPR) && !wp_n) return 0;
    if (wsm_susp) return k == K_ARR || k == K_STAT || k == P_RES;
    if (wsm_busy) return k == K_STAT || (k == P_SUSP && m_last == 2);
    return !(k == P_SUSP || k == P_RES);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_pulse = 0; m_sect = 0; m_last = 0;
    end else begin
      m_pulse = 0;
      if (wr_en) begin
        int k;
        q.push_back('{int'(wr_addr), int'(wr_data)});
        k = classify();
        if (k == K_PREFIX) ;
        else if (k == K_ESET || k == K_PSET) begin
          if (!allowed(k)) q.delete();
        end else begin
          if (k != K_BAD && allowed(k)) begin
            case (k)
              K_ARR:  m_mode = 0;
              K_ID:   m_mode = 2;
              K_STAT: m_mode = 1;
              default: begin
                m_pulse = 1 << k;
                if (k != P_CLR) m_mode = 1;
                if (k == P_PROG || k == P_PROT || k == P_UNPR) m_last = 0;
                if (k == P_CHIP) m_last = 1;
                if (k == P_SECT) m_last = 2;
                if (k == P_SECT || k == P_PROT || k == P_UNPR) m_sect = wr_addr[19:16];
              end
            endcase
          end
          q.delete();
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge; pulses seen are accumulated.
  logic [7:0] seen = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 rd_sel vs model", rd_sel, m_mode);
      check("R12 pulses vs model", dut_p, m_pulse);
      if (m_pulse[P_SECT] || m_pulse[P_PROT] || m_pulse[P_UNPR])
        check("R5 sect_addr vs model", sect_addr, m_sect);
      seen = seen | dut_p;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a[19:0]; wr_data = d[15:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd3(int d);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, d);
  endtask

  task automatic cmd6(int s, int fa, int fd);
    cmd3(s); wr('h5555, 'hAA); wr('h2AAA, 'h55); wr(fa, fd);
  endtask

  task automatic expect_seen(string tag, int exp);
    @(negedge clk);
    check(tag, seen, exp);
    seen = '0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd_sel", rd_sel, 0);
    check("R1 reset pulses", dut_p, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cmd3('h70); check("R3 status select", rd_sel, 1);
    cmd3('hF0); check("R3 array select", rd_sel, 0);
    // R2: upper address bits and high data byte ignored
    wr('hF5555, 'h12AA); wr('h72AAA, 'hFF55); wr('h35555, 'h3490);
    check("R2 masked unlock to id", rd_sel, 2);

    rd_addr = 20'h00000; #1 check("R11 mfr code", id_byte, 'hC2);
    rd_addr = 20'h00001; #1 check("R11 device code", id_byte, 'hFA);
    rd_addr = 20'h50002; #1 check("R11 protected sector", id_byte, 'hC2);
    rd_addr = 20'h40002; #1 check("R11 open sector", id_byte, 'h00);
    rd_addr = 20'h50003; #1 check("R11 offset 3", id_byte, 'h00);

    cmd3('hA0); check("R4 program status", rd_sel, 1);
    expect_seen("R4 program pulse", 1 << P_PROG);
    wsm_busy = 1'b1;
    cmd3('hF0); check("R8 busy program refuses reset", rd_sel, 1);
    wr('h00010, 'hB0);
    cmd3('h50);
    expect_seen("R8 busy program no pulses", 0);
    wsm_busy = 1'b0;

    cmd3('hF0);
    cmd3('h50); check("R10 clear keeps mode", rd_sel, 0);
    expect_seen("R10 clear pulse", 1 << P_CLR);

    cmd6('h80, 'h5555, 'h10);
    expect_seen("R5 chip erase pulse", 1 << P_CHIP);
    wsm_busy = 1'b1;
    wr('h01234, 'hB0);
    expect_seen("R7 no suspend in chip erase", 0);
    wsm_busy = 1'b0;

    cmd6('h80, 'h71234, 'h30);
    check("R5 sector field", sect_addr, 7);
    expect_seen("R5 sector erase pulse", 1 << P_SECT);
    wsm_busy = 1'b1;
    cmd3('hF0); check("R8 erase busy refuses reset", rd_sel, 1);
    wr('h00003, 'hB0);
    expect_seen("R7 suspend pulse", 1 << P_SUSP);
    wsm_susp = 1'b1;
    cmd3('h90); check("R8 suspended refuses id", rd_sel, 1);
    cmd3('hF0); check("R8 suspended accepts reset", rd_sel, 0);
    wr('h00000, 'hD0); check("R7 resume status", rd_sel, 1);
    expect_seen("R7 resume pulse", 1 << P_RES);
    wsm_susp = 1'b0; wsm_busy = 1'b0;
    wr('h00000, 'hD0);
    expect_seen("R7 resume ignored when idle", 0);

    cmd6('h60, 'hA0000, 'h20); check("R6 protect sector", sect_addr, 'hA);
    expect_seen("R6 protect pulse", 1 << P_PROT);
    cmd6('h60, 'h30000, 'h40); check("R6 unprotect sector", sect_addr, 3);
    expect_seen("R6 unprotect pulse", 1 << P_UNPR);
    cmd3('hF0);
    wp_n = 1'b0;
    cmd6('h60, 'h20000, 'h20); check("R6 refused keeps mode", rd_sel, 0);
    expect_seen("R6 wp refuses protect", 0);
    wp_n = 1'b1;

    wr('h5555, 'hAA); wr('h2AAB, 'h55); wr('h5555, 'h70);
    check("R9 bad unlock no mode change", rd_sel, 0);
    cmd3('h80); wr('h5555, 'hAA); wr('h2AAA, 'h54); wr('h5555, 'h10);
    expect_seen("R9 broken erase no pulse", 0);
    cmd3('h90); check("R9 recovers after error", rd_sel, 2);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule